// File: doc/BRIEF.md
# Multi-Channel Context-Switched FIFO

This block keeps several logical FIFOs, one per channel, inside one shared word memory. Each channel owns an equal slice of that memory. The write side and the read side each pick a channel through their own channel-number input. Only the selected channel's pointer is held in each side's working register. Every side also keeps a small per-channel store of its own pointer. The other side reads this store to learn how far its partner has progressed.

When a side's channel number changes, that side drops its channel-valid output and runs a two-step switch. First it saves its working pointer into the store slot of the old channel. Then it loads the new channel's slot. After that, channel-valid rises again. Transfers are bursts of a fixed length set by a parameter, which can differ between the two sides. A burst is a request held by the user and answered by one acknowledge per word on consecutive cycles. The read side also answers a status request once its channel is valid.

Each side writes its pointer back to its store at the end of every burst. When both sides point at the same channel, each therefore sees the other's finished bursts. The default parameters are 4 channels, 8 words per channel, 8-bit words, write bursts of 4 and read bursts of 2. NCH and DEPTH must be powers of two, with NCH at least 2.

Top module: `mchan_fifo`

## Requirements
- R1: After reset, both sides select channel 0 with channel-valid high, both levels at 0, rd_empty_o high, wr_full_o low, and no acknowledge.
- R2: A write request is acknowledged in the cycle it is seen, provided the write channel is valid, no burst is running, and the channel's vacancy is at least WR_BURST. wr_ack_o then stays high for exactly WR_BURST consecutive cycles, and each of those cycles stores wr_data_i.
- R3: While the write channel's vacancy is below WR_BURST, a write request gets no acknowledge, and wr_level_o never exceeds DEPTH.
- R4: A read request is answered with RD_BURST consecutive acknowledges when the channel holds at least RD_BURST committed words. In each acknowledged cycle, rd_data_o carries the channel's oldest unread word, so words leave in the order they were written.
- R5: While the read channel holds fewer than RD_BURST committed words, a read request gets no acknowledge.
- R6: A burst stops after exactly its configured word count, even if the request stays high. No new burst starts on that side until the request has been sampled low at least once.
- R7: A side whose channel input differs from its current channel drives channel-valid low in that same cycle. If its request is low and no burst is running, the switch spends one cycle saving and one cycle loading. Channel-valid is high again in the fourth cycle, counting the cycle in which the new number first appeared.
- R8: While a side's request is high, a change of its channel number does not start the switch, and channel-valid stays low. Once the request drops, the switch runs with the timing of R7.
- R9: Each channel's pointers survive any number of switches on either side. Words written to one channel are read back only from that channel.
- R10: When both sides select the same channel, each side's level takes in a burst completed by the other side from the cycle after that burst's last acknowledge.
- R11: rd_stat_ack_o is high exactly in the cycles where rd_stat_req_i and the read channel-valid are both high. A status request raised in the same cycle as a read channel change is therefore acknowledged only once that switch has finished.
- R12: While channel-valid is high, each side reports the channel occupancy. wr_level_o is the write side's view and rd_level_o is the read side's view. wr_full_o is high when wr_level_o equals DEPTH, and rd_empty_o is high when rd_level_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_chan_i | input | $clog2(NCH) | Write-side channel number |
| wr_req_i | input | 1 | Write burst request |
| wr_data_i | input | DW | Write word, taken in each acknowledged cycle |
| wr_ack_o | output | 1 | One word accepted this cycle |
| wr_chan_valid_o | output | 1 | Write-side channel switch complete |
| wr_level_o | output | $clog2(DEPTH)+1 | Occupancy as seen by the write side |
| wr_full_o | output | 1 | Write channel full |
| rd_chan_i | input | $clog2(NCH) | Read-side channel number |
| rd_req_i | input | 1 | Read burst request |
| rd_ack_o | output | 1 | One word delivered this cycle |
| rd_data_o | output | DW | Read word, valid while rd_ack_o is high |
| rd_chan_valid_o | output | 1 | Read-side channel switch complete |
| rd_level_o | output | $clog2(DEPTH)+1 | Occupancy as seen by the read side |
| rd_empty_o | output | 1 | Read channel empty |
| rd_stat_req_i | input | 1 | Status request on the read side |
| rd_stat_ack_o | output | 1 | Status request answered |

## Verification
The bench holds requests well past the end of each burst. A design that counts acknowledges by the request, rather than by the burst length, gives extra words and breaks the burst count. It fills a channel to exactly DEPTH and drains it to zero, so an off-by-one in the vacancy or occupancy test shows up as an overflow, a read of stale data, or a missing acknowledge. It changes channels, sometimes with a status request in the same cycle and sometimes with the request still high. A switch that is too short, starts under an active request, or loses the saved pointer either returns channel-valid at the wrong cycle or reads another channel's words. Write and read share one channel while the bench tracks the levels. A missing write-back then leaves one side's level stuck.

// File: rtl/mchan_fifo_pkg.sv
package mchan_fifo_pkg;

    // Context switch phases of one side
    typedef enum logic [1:0] {
        SW_LIVE = 2'd0,
        SW_SAVE = 2'd1,
        SW_LOAD = 2'd2
    } sw_state_e;

endpackage

// File: rtl/mchan_mem.sv
module mchan_mem #(
    parameter  int DW    = 8,
    parameter  int ABITS = 5,
    localparam int WORDS = 1 << ABITS
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [ABITS-1:0] waddr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [ABITS-1:0] raddr_i,
    output logic [DW-1:0]    rdata_o
);

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/mchan_side.sv
module mchan_side
    import mchan_fifo_pkg::*;
#(
    parameter  int NCH   = 4,
    parameter  int DEPTH = 8,
    parameter  int BURST = 4,
    parameter  bit IS_WR = 1'b1,
    localparam int CW    = $clog2(NCH),
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int BCW   = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] chan_i,
    input  logic          req_i,
    output logic          ack_o,
    output logic          valid_o,
    output logic [CW-1:0] cur_o,
    output logic [PW-1:0] own_o,
    input  logic [PW-1:0] peer_i,
    input  logic [CW-1:0] look_ch_i,
    output logic [PW-1:0] look_o,
    output logic [PW-1:0] level_o
);

    localparam logic [PW:0] DEPTH_X = (PW+1)'(DEPTH);
    localparam logic [PW:0] BURST_X = (PW+1)'(BURST);
    localparam logic [BCW-1:0] LAST_CNT = BCW'(BURST - 1);

    typedef struct packed {
        sw_state_e                 st;
        logic [CW-1:0]             cur;
        logic [PW-1:0]             own;
        logic                      active;
        logic                      hold;
        logic [BCW-1:0]            cnt;
        logic [NCH-1:0][PW-1:0]    store;
    } side_t;

    side_t q, n;
    logic [PW-1:0] level;
    logic          fits;
    logic          live;
    logic          start;
    logic          ack;

    // Room test differs by direction: vacancy for the producer, data for the consumer
    if (IS_WR) begin : g_room
        assign level = q.own - peer_i;
        assign fits  = (DEPTH_X - {1'b0, level}) >= BURST_X;
    end else begin : g_data
        assign level = peer_i - q.own;
        assign fits  = {1'b0, level} >= BURST_X;
    end

    always_comb begin
        n     = q;
        live  = (q.st == SW_LIVE) && (chan_i == q.cur);
        start = live && req_i && !q.hold && !q.active && fits;
        ack   = start || q.active;

        case (q.st)
            SW_LIVE: begin
                if ((chan_i != q.cur) && !req_i && !q.active) begin
                    n.st = SW_SAVE;
                end
            end
            SW_SAVE: begin
                n.store[q.cur] = q.own;
                n.cur          = chan_i;
                n.st           = SW_LOAD;
            end
            SW_LOAD: begin
                n.own = q.store[q.cur];
                n.st  = SW_LIVE;
            end
            default: n.st = SW_LIVE;
        endcase

        if (ack) begin
            n.own = q.own + 1'b1;
            if (q.cnt == LAST_CNT) begin
                n.cnt          = '0;
                n.active       = 1'b0;
                n.hold         = 1'b1;
                n.store[q.cur] = q.own + 1'b1;
            end else begin
                n.cnt    = q.cnt + 1'b1;
                n.active = 1'b1;
            end
        end else if (!req_i) begin
            n.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign ack_o   = ack;
    assign valid_o = live;
    assign cur_o   = q.cur;
    assign own_o   = q.own;
    assign look_o  = q.store[look_ch_i];
    assign level_o = level;

    // R2 / R4: words only move on a settled channel
    p_ack_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (q.st == SW_LIVE));

    // R6: the cycle after the last word carries no acknowledge
    p_burst_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && (q.cnt == LAST_CNT)) |=> !ack_o);

    // R3: occupancy never exceeds the channel slice
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, level_o} <= DEPTH_X));

    // R7: save is followed by load, load by the live phase
    p_save_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_SAVE) |=> (q.st == SW_LOAD));
    p_load_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SW_LOAD) |=> (q.st == SW_LIVE));

    // R8: a switch only starts from a cycle with the request low
    p_switch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == SW_SAVE) && ($past(q.st) == SW_LIVE)) |-> !$past(req_i));

endmodule

// File: rtl/mchan_fifo.sv
module mchan_fifo
    import mchan_fifo_pkg::*;
#(
    parameter  int NCH      = 4,
    parameter  int DEPTH    = 8,
    parameter  int DW       = 8,
    parameter  int WR_BURST = 4,
    parameter  int RD_BURST = 2,
    localparam int CW       = $clog2(NCH),
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wr_chan_i,
    input  logic          wr_req_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_ack_o,
    output logic          wr_chan_valid_o,
    output logic [PW-1:0] wr_level_o,
    output logic          wr_full_o,
    input  logic [CW-1:0] rd_chan_i,
    input  logic          rd_req_i,
    output logic          rd_ack_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_chan_valid_o,
    output logic [PW-1:0] rd_level_o,
    output logic          rd_empty_o,
    input  logic          rd_stat_req_i,
    output logic          rd_stat_ack_o
);

    logic [CW-1:0] w_cur, r_cur;
    logic [PW-1:0] w_own, r_own;
    logic [PW-1:0] w_store_at_r, r_store_at_w;

    mchan_side #(
        .NCH(NCH), .DEPTH(DEPTH), .BURST(WR_BURST), .IS_WR(1'b1)
    ) u_wside (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_i   (wr_chan_i),
        .req_i    (wr_req_i),
        .ack_o    (wr_ack_o),
        .valid_o  (wr_chan_valid_o),
        .cur_o    (w_cur),
        .own_o    (w_own),
        .peer_i   (r_store_at_w),
        .look_ch_i(r_cur),
        .look_o   (w_store_at_r),
        .level_o  (wr_level_o)
    );

    mchan_side #(
        .NCH(NCH), .DEPTH(DEPTH), .BURST(RD_BURST), .IS_WR(1'b0)
    ) u_rside (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_i   (rd_chan_i),
        .req_i    (rd_req_i),
        .ack_o    (rd_ack_o),
        .valid_o  (rd_chan_valid_o),
        .cur_o    (r_cur),
        .own_o    (r_own),
        .peer_i   (w_store_at_r),
        .look_ch_i(w_cur),
        .look_o   (r_store_at_w),
        .level_o  (rd_level_o)
    );

    mchan_mem #(
        .DW(DW), .ABITS(CW + AW)
    ) u_mem (
        .clk    (clk),
        .we_i   (wr_ack_o),
        .waddr_i({w_cur, w_own[AW-1:0]}),
        .wdata_i(wr_data_i),
        .raddr_i({r_cur, r_own[AW-1:0]}),
        .rdata_o(rd_data_o)
    );

    assign wr_full_o     = (wr_level_o == PW'(DEPTH));
    assign rd_empty_o    = (rd_level_o == '0);
    assign rd_stat_ack_o = rd_stat_req_i && rd_chan_valid_o;

    // R10: a read never starts on a channel the read side sees as empty
    p_read_has_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_o && !$past(rd_ack_o)) |-> !rd_empty_o);

endmodule

// File: tb/mchan_fifo_bench.sv
module mchan_fifo_bench;
    localparam int NCH = 4, DEPTH = 8, DW = 8, WB = 4, RB = 2;
    localparam int CW = $clog2(NCH), PW = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [CW-1:0] wr_chan, rd_chan;
    logic wr_req, rd_req, rd_stat_req;
    logic [DW-1:0] wr_data;
    logic wr_ack, wr_cv, wr_full, rd_ack, rd_cv, rd_empty, rd_stat_ack;
    logic [PW-1:0] wr_level, rd_level;
    logic [DW-1:0] rd_data;

    mchan_fifo #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW), .WR_BURST(WB), .RD_BURST(RB)) u_mchan_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_chan_i(wr_chan), .wr_req_i(wr_req), .wr_data_i(wr_data), .wr_ack_o(wr_ack),
        .wr_chan_valid_o(wr_cv), .wr_level_o(wr_level), .wr_full_o(wr_full),
        .rd_chan_i(rd_chan), .rd_req_i(rd_req), .rd_ack_o(rd_ack), .rd_data_o(rd_data),
        .rd_chan_valid_o(rd_cv), .rd_level_o(rd_level), .rd_empty_o(rd_empty),
        .rd_stat_req_i(rd_stat_req), .rd_stat_ack_o(rd_stat_ack)
    );

    int n_chk = 0, n_fail = 0;
    bit run = 0, done = 0;
    int wa_seen = 0, ra_seen = 0;

    // behavioural reference: counts of words per channel and a queue of data per channel
    int ph[2], mcur[2], mcnt[2];
    bit mact[2], mhold[2];
    int wtot[NCH], wcom[NCH], rtot[NCH], rcom[NCH];
    logic [DW-1:0] dq[NCH][$];
    int wseq = 0;
    bit pend = 0;
    bit ev[2], ea[2], rq[2], ft, sw;
    int lvl[2], ch[2], c, bl;

    assign wr_data = DW'(wseq * 7 + 3);
    always @(posedge clk) wseq <= wseq + int'(pend);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        pend = 0;
        if (run) begin
            ch[0] = wr_chan; ch[1] = rd_chan; rq[0] = wr_req; rq[1] = rd_req;
            for (int s = 0; s < 2; s++) begin
                ev[s]  = (ph[s] == 0) && (ch[s] == mcur[s]);
                lvl[s] = (s == 0) ? wtot[mcur[0]] - rcom[mcur[0]] : wcom[mcur[1]] - rtot[mcur[1]];
                ft     = (s == 0) ? (DEPTH - lvl[s] >= WB) : (lvl[s] >= RB);
                ea[s]  = mact[s] || (ev[s] && rq[s] && !mhold[s] && ft);
            end
            if (wr_ack) wa_seen++;
            if (rd_ack) ra_seen++;
            chk("R2 wr_ack", wr_ack, ea[0]);
            chk("R4 rd_ack", rd_ack, ea[1]);
            chk("R7 wr_chan_valid", wr_cv, ev[0]);
            chk("R7 rd_chan_valid", rd_cv, ev[1]);
            chk("R11 rd_stat_ack", rd_stat_ack, ev[1] && rd_stat_req);
            if (ev[0]) begin
                chk("R12 wr_level", wr_level, lvl[0]);
                chk("R12 wr_full", wr_full, lvl[0] == DEPTH);
            end
            if (ev[1]) begin
                chk("R10 rd_level", rd_level, lvl[1]);
                chk("R12 rd_empty", rd_empty, lvl[1] == 0);
            end
            if (ea[1]) begin
                if (dq[mcur[1]].size() > 0) chk("R4/R9 rd_data", rd_data, dq[mcur[1]][0]);
                else chk("R5 read of empty channel", 1, 0);
            end
            // advance the reference to the state after the coming edge
            for (int s = 0; s < 2; s++) begin
                sw = (ph[s] == 0) && (ch[s] != mcur[s]) && !rq[s] && !mact[s];
                if (ph[s] == 1) begin mcur[s] = ch[s]; ph[s] = 2; end
                else if (ph[s] == 2) ph[s] = 0;
                else if (sw) ph[s] = 1;
                bl = (s == 0) ? WB : RB;
                if (ea[s]) begin
                    c = mcur[s];
                    if (s == 0) begin dq[c].push_back(wr_data); wtot[c]++; pend = 1; end
                    else begin void'(dq[c].pop_front()); rtot[c]++; end
                    if (mcnt[s] == bl - 1) begin
                        mcnt[s] = 0; mact[s] = 0; mhold[s] = 1;
                        if (s == 0) wcom[c] = wtot[c]; else rcom[c] = rtot[c];
                    end else begin
                        mcnt[s]++; mact[s] = 1;
                    end
                end else if (!rq[s]) begin
                    mhold[s] = 0;
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the sequence ended");
            finish_up();
        end
    end

    initial begin
        int a0;
        for (int s = 0; s < 2; s++) begin ph[s] = 0; mcur[s] = 0; mcnt[s] = 0; mact[s] = 0; mhold[s] = 0; end
        for (int k = 0; k < NCH; k++) begin wtot[k] = 0; wcom[k] = 0; rtot[k] = 0; rcom[k] = 0; end
        rst_n = 0; wr_chan = 0; rd_chan = 0; wr_req = 0; rd_req = 0; rd_stat_req = 0;
        tick(3);
        rst_n = 1; run = 1;

        // R1 reset state
        @(negedge clk);
        chk("R1 wr_chan_valid", wr_cv, 1); chk("R1 rd_chan_valid", rd_cv, 1);
        chk("R1 wr_level", wr_level, 0); chk("R1 rd_level", rd_level, 0);
        chk("R1 rd_empty", rd_empty, 1); chk("R1 wr_full", wr_full, 0);
        chk("R1 acks", {wr_ack, rd_ack}, 0);
        @(posedge clk); #1;

        // R2 / R6: request held well past the burst
        a0 = wa_seen; wr_req = 1; tick(7); wr_req = 0; tick(1);
        chk("R6 write burst length", wa_seen - a0, WB);
        a0 = wa_seen; wr_req = 1; tick(5); wr_req = 0; tick(1);
        chk("R2 second write burst", wa_seen - a0, WB);
        @(negedge clk); chk("R12 wr_full at capacity", wr_full, 1);
        chk("R10 read side sees writes", rd_level, DEPTH);
        @(posedge clk); #1;

        // R3: no room for another burst
        a0 = wa_seen; wr_req = 1; tick(6); wr_req = 0; tick(1);
        chk("R3 write blocked when full", wa_seen - a0, 0);

        // R4 drain in bursts, request held one extra cycle
        for (int b = 0; b < 4; b++) begin
            a0 = ra_seen; rd_req = 1; tick(3); rd_req = 0; tick(1);
            chk("R6 read burst length", ra_seen - a0, RB);
        end
        @(negedge clk); chk("R12 rd_empty after drain", rd_empty, 1);
        chk("R10 write side sees reads", wr_level, 0);
        @(posedge clk); #1;
        a0 = ra_seen; rd_req = 1; tick(5); rd_req = 0; tick(1);
        chk("R5 read blocked when empty", ra_seen - a0, 0);

        // R7 write side switch timing
        wr_chan = 2;
        repeat (3) begin @(negedge clk); chk("R7 valid low during switch", wr_cv, 0); end
        @(negedge clk); chk("R7 valid back after switch", wr_cv, 1);
        @(posedge clk); #1;
        wr_req = 1; tick(5); wr_req = 0; tick(1);

        // R11 status request raised with the channel change
        rd_chan = 2; rd_stat_req = 1;
        repeat (3) begin @(negedge clk); chk("R11 status ack held off", rd_stat_ack, 0); end
        @(negedge clk); chk("R11 status ack after switch", rd_stat_ack, 1);
        chk("R9 new channel level", rd_level, WB);
        @(posedge clk); #1; rd_stat_req = 0;
        for (int b = 0; b < 2; b++) begin rd_req = 1; tick(3); rd_req = 0; tick(1); end

        // R9 isolation across channels 1 and 3
        wr_chan = 1; tick(5); wr_req = 1; tick(5); wr_req = 0; tick(1);
        wr_chan = 3; tick(5); wr_req = 1; tick(5); wr_req = 0; tick(1);
        rd_chan = 3; tick(5);
        @(negedge clk); chk("R9 channel 3 level", rd_level, WB);
        @(posedge clk); #1;
        a0 = ra_seen;
        for (int b = 0; b < 2; b++) begin rd_req = 1; tick(3); rd_req = 0; tick(1); end
        chk("R9 channel 3 words", ra_seen - a0, WB);
        rd_chan = 1; tick(5);
        for (int b = 0; b < 2; b++) begin rd_req = 1; tick(3); rd_req = 0; tick(1); end
        @(negedge clk); chk("R9 channel 1 drained", rd_empty, 1);
        @(posedge clk); #1;

        // R8 channel change while the request stays high
        a0 = wa_seen; wr_req = 1; tick(6);
        wr_chan = 0; tick(5);
        @(negedge clk); chk("R8 no switch under request", wr_cv, 0);
        chk("R8 no extra words", wa_seen - a0, WB);
        @(posedge clk); #1;
        wr_req = 0;
        repeat (3) begin @(negedge clk); chk("R8 switch after request drop", wr_cv, 0); end
        @(negedge clk); chk("R8 valid after delayed switch", wr_cv, 1);
        chk("R9 channel 0 pointers kept", wr_level, 0);
        @(posedge clk); #1;
        tick(2);
        finish_up();
    end
endmodule